// File: doc/BRIEF.md
# Page-mode DRAM access controller

This block sits between a simple synchronous host port and an asynchronous 1M x 4 dynamic memory with multiplexed row and column addressing. A host request carries a 20-bit word address, a direction bit and 4 bits of write data. The controller turns each request into strobe sequences on the memory side. These are the row strobe, the column strobe, the write strobe and the output enable, all active low. There is also a 10-bit multiplexed address bus and a split data path with a driver enable.

After a row is activated it stays open. A later request to the same row is served with a column-strobe cycle only. A request to a different row first precharges the open row and then activates the new one. Every row-strobe low period is bounded by a parameter. When the remaining budget cannot cover another full page cycle, the controller closes the row on its own, even while hits keep arriving.

The column address goes onto the bus one cycle before the column strobe falls, while that strobe is still high. Writes always use early-write ordering, so the memory never drives its outputs during a write. All timings are whole clock cycles set by parameters. The parameters must satisfy 1 <= T_RD <= T_CAS and T_RAH + T_CAS + T_CP + 2 <= T_RAS_MAX.

Top module: `dram_page_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, the row, column, write and output-enable strobes are high, dram_dq_oe_o is low, rsp_valid_o is low, no row is open, and req_ready_o is high.
- R2: The address bus holds bits [19:10] of the request address when the row strobe falls. It holds bits [9:0] when the column strobe falls. The column strobe is low only while the row strobe is low.
- R3: A request whose row equals the open row, when enough budget is left, is served without any change of the row strobe.
- R4: A request to a row other than the open one raises the row strobe for exactly T_RP cycles. The strobe then falls with the new row on the address bus.
- R5: The row strobe never stays low for more than T_RAS_MAX consecutive cycles. With no requests arriving, an open row is closed by the controller itself.
- R6: For a write, the write strobe is low and dram_dq_oe_o is high during the cycle before the column strobe falls. The output enable stays high for as long as the write strobe is low. The written data is what a later read of that address returns.
- R7: The output enable goes low only while the column strobe is low during a read. It is never low while dram_dq_oe_o is high or the write strobe is low.
- R8: Read data is sampled T_RD cycles after the column strobe falls. It is returned on rsp_rdata_o with rsp_valid_o high for exactly one cycle, in the cycle that follows the sample.
- R9: req_ready_o is low from the cycle after a request is accepted until its sequence has finished. It is also low while the controller closes a row for lack of budget.
- R10: Each column-strobe low pulse lasts exactly T_CAS cycles. Between two pulses the strobe stays high for at least T_CP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata_i | input | 4 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| rsp_rdata_o | output | 4 | Read data |
| dram_addr_o | output | 10 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Data toward the memory |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 4 | Data from the memory |

## Verification
Two functions can fall in the same idle cycle: serving a page hit, and the forced row closure when the row-strobe budget runs out. A hit that arrives when too little budget is left must turn into a precharge and reactivation, never into a page cycle that overruns the limit. This is provoked with back-to-back hits to one row, and with random idle gaps between requests that move the arrival point across the budget edge. It is judged by a memory model in the bench. The model measures every row-strobe low period against T_RAS_MAX and counts row activations, and it returns junk data whenever the strobes or the access delay are not satisfied. Read results are compared with a reference copy of every accepted write.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_CASL,
    ST_CASH
  } seq_state_e;
endpackage

// File: rtl/dram_step_timer.sv
module dram_step_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dram_row_track.sv
module dram_row_track #(
  parameter int ROW_W     = 10,
  parameter int T_RAS_MAX = 24,
  parameter int PAGE_LEN  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             open_o,
  output logic             hit_o,
  output logic             budget_out_o
);
  localparam int RC_W = $clog2(T_RAS_MAX + 1) + 1;

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [RC_W-1:0]  ras_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  // cycles the row strobe has already been low before the current one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ras_cnt_q <= '0;
    else if (ras_n_i)           ras_cnt_q <= '0;
    else if (ras_cnt_q != '1)   ras_cnt_q <= ras_cnt_q + 1'b1;
  end

  assign open_o       = open_q;
  assign hit_o        = open_q && (row_q == cmp_row_i);
  // a page cycle plus the closing idle cycle must still fit
  assign budget_out_o = (int'(ras_cnt_q) + PAGE_LEN + 2) > T_RAS_MAX;

  AST_RAS_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_i |-> (int'(ras_cnt_q) < T_RAS_MAX)); // R5
  AST_OPEN_TRACKS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q == !ras_n_i); // R3
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DQ_W      = 4,
  parameter int T_RAH     = 2,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 2,
  parameter int T_RP      = 3,
  parameter int T_RD      = 2,
  parameter int T_RAS_MAX = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_we_i,
  input  logic [ROW_W+COL_W-1:0]   req_addr_i,
  input  logic [DQ_W-1:0]          req_wdata_i,
  output logic                     rsp_valid_o,
  output logic [DQ_W-1:0]          rsp_rdata_o,
  output logic [COL_W-1:0]         dram_addr_o,
  output logic                     dram_ras_no,
  output logic                     dram_cas_no,
  output logic                     dram_we_no,
  output logic                     dram_oe_no,
  output logic [DQ_W-1:0]          dram_dq_o,
  output logic                     dram_dq_oe_o,
  input  logic [DQ_W-1:0]          dram_dq_i
);
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int PAGE_LEN = 1 + T_CAS + T_CP;
  localparam int MAX_A    = (T_RAH > T_CAS) ? T_RAH : T_CAS;
  localparam int MAX_B    = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int MAX_T    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_T + 1);
  localparam int AW       = (ROW_W > COL_W) ? ROW_W : COL_W;

  seq_state_e state_q, state_d;

  logic              ras_n_q, ras_n_d, cas_n_q, cas_n_d;
  logic              we_n_q, we_n_d, oe_n_q, oe_n_d;
  logic [COL_W-1:0]  addr_q, addr_d;
  logic              dq_oe_q, dq_oe_d;
  logic [DQ_W-1:0]   dq_q, dq_d;
  logic              pend_q, pend_d;
  logic              rsp_q, rsp_d;
  logic [DQ_W-1:0]   rdata_q, rdata_d;
  logic              rq_we_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DQ_W-1:0]   rq_wdata_q;
  logic              capture;

  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_len, tmr_cnt;

  logic              row_open, row_hit, budget_out, open_set, row_close;

  logic              sel_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [DQ_W-1:0]   sel_wdata;
  logic [ROW_W-1:0]  sel_row;
  logic [COL_W-1:0]  sel_col;

  dram_step_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .cnt_o  (tmr_cnt),
    .done_o (tmr_done)
  );

  dram_row_track #(
    .ROW_W     (ROW_W),
    .T_RAS_MAX (T_RAS_MAX),
    .PAGE_LEN  (PAGE_LEN)
  ) u_row (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ras_n_i      (ras_n_q),
    .open_i       (open_set),
    .close_i      (row_close),
    .row_i        (sel_row),
    .cmp_row_i    (req_addr_i[ADDR_W-1:COL_W]),
    .open_o       (row_open),
    .hit_o        (row_hit),
    .budget_out_o (budget_out)
  );

  // in idle the live request is used, later the captured one
  always_comb begin
    if (state_q == ST_IDLE) begin
      sel_we    = req_we_i;
      sel_addr  = req_addr_i;
      sel_wdata = req_wdata_i;
    end else begin
      sel_we    = rq_we_q;
      sel_addr  = rq_addr_q;
      sel_wdata = rq_wdata_q;
    end
    sel_row = sel_addr[ADDR_W-1:COL_W];
    sel_col = sel_addr[COL_W-1:0];
  end

  assign req_ready_o = (state_q == ST_IDLE) && !(row_open && budget_out);

  always_comb begin
    state_d   = state_q;
    ras_n_d   = ras_n_q;
    cas_n_d   = cas_n_q;
    we_n_d    = we_n_q;
    oe_n_d    = oe_n_q;
    addr_d    = addr_q;
    dq_oe_d   = dq_oe_q;
    dq_d      = dq_q;
    pend_d    = pend_q;
    rsp_d     = 1'b0;
    rdata_d   = rdata_q;
    capture   = 1'b0;
    tmr_load  = 1'b0;
    tmr_len   = '0;
    open_set  = 1'b0;
    row_close = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (row_open && budget_out) begin
          state_d   = ST_PRE;
          ras_n_d   = 1'b1;
          row_close = 1'b1;
          pend_d    = 1'b0;
          tmr_load  = 1'b1;
          tmr_len   = CNT_W'(T_RP - 1);
        end else if (req_valid_i) begin
          capture = 1'b1;
          if (row_hit) begin
            state_d = ST_COL;
            addr_d  = sel_col;
            we_n_d  = !sel_we;
            dq_oe_d = sel_we;
            dq_d    = sel_wdata;
          end else if (row_open) begin
            state_d   = ST_PRE;
            ras_n_d   = 1'b1;
            row_close = 1'b1;
            pend_d    = 1'b1;
            tmr_load  = 1'b1;
            tmr_len   = CNT_W'(T_RP - 1);
          end else begin
            state_d  = ST_ACT;
            ras_n_d  = 1'b0;
            addr_d   = AW'(sel_row);
            open_set = 1'b1;
            tmr_load = 1'b1;
            tmr_len  = CNT_W'(T_RAH - 1);
          end
        end
      end
      ST_PRE: begin
        if (tmr_done) begin
          if (pend_q) begin
            state_d  = ST_ACT;
            ras_n_d  = 1'b0;
            addr_d   = AW'(sel_row);
            open_set = 1'b1;
            pend_d   = 1'b0;
            tmr_load = 1'b1;
            tmr_len  = CNT_W'(T_RAH - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_ACT: begin
        if (tmr_done) begin
          state_d = ST_COL;
          addr_d  = sel_col;
          we_n_d  = !sel_we;
          dq_oe_d = sel_we;
          dq_d    = sel_wdata;
        end
      end
      ST_COL: begin
        state_d  = ST_CASL;
        cas_n_d  = 1'b0;
        oe_n_d   = rq_we_q;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(T_CAS - 1);
      end
      ST_CASL: begin
        if (!rq_we_q && (tmr_cnt == CNT_W'(T_CAS - T_RD))) begin
          rsp_d   = 1'b1;
          rdata_d = dram_dq_i;
        end
        if (tmr_done) begin
          state_d  = ST_CASH;
          cas_n_d  = 1'b1;
          oe_n_d   = 1'b1;
          we_n_d   = 1'b1;
          dq_oe_d  = 1'b0;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(T_CP - 1);
        end
      end
      ST_CASH: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ras_n_q    <= 1'b1;
      cas_n_q    <= 1'b1;
      we_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      addr_q     <= '0;
      dq_oe_q    <= 1'b0;
      dq_q       <= '0;
      pend_q     <= 1'b0;
      rsp_q      <= 1'b0;
      rdata_q    <= '0;
      rq_we_q    <= 1'b0;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
    end else begin
      state_q <= state_d;
      ras_n_q <= ras_n_d;
      cas_n_q <= cas_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      addr_q  <= addr_d;
      dq_oe_q <= dq_oe_d;
      dq_q    <= dq_d;
      pend_q  <= pend_d;
      rsp_q   <= rsp_d;
      rdata_q <= rdata_d;
      if (capture) begin
        rq_we_q    <= req_we_i;
        rq_addr_q  <= req_addr_i;
        rq_wdata_q <= req_wdata_i;
      end
    end
  end

  assign rsp_valid_o  = rsp_q;
  assign rsp_rdata_o  = rdata_q;
  assign dram_addr_o  = addr_q;
  assign dram_ras_no  = ras_n_q;
  assign dram_cas_no  = cas_n_q;
  assign dram_we_no   = we_n_q;
  assign dram_oe_no   = oe_n_q;
  assign dram_dq_o    = dq_q;
  assign dram_dq_oe_o = dq_oe_q;

  AST_CAS_UNDER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no); // R2
  AST_EARLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_we_no) |-> ($past(!dram_we_no) && $past(dram_dq_oe_o))); // R6
  AST_WRITE_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> dram_oe_no); // R6
  AST_OE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> (!dram_cas_no && !dram_dq_oe_o)); // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R8
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (dram_cas_no && !dram_dq_oe_o)); // R9
  AST_CAS_RISE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_cas_no) |-> (state_q == ST_CASH)); // R10
endmodule

// File: tb/dram_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_page_ctrl_tb_top;
  localparam int T_RAH = 2, T_CAS = 3, T_CP = 2, T_RP = 3, T_RD = 2, T_RAS_MAX = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [9:0]  d_addr;
  logic        ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]  dq_out;
  logic [3:0]  dq_in = 4'h0;

  dram_page_ctrl #(
    .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RD(T_RD), .T_RAS_MAX(T_RAS_MAX)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_addr_o(d_addr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_oe_no(oe_n), .dram_dq_o(dq_out),
    .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_in)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  logic [3:0] ref_mem [int];
  logic [3:0] dmem [int];
  function automatic logic [3:0] ref_rd(input logic [19:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
  endfunction

  // memory model and strobe monitors
  logic [9:0] cur_row = '0, cur_col = '0, m_row = '0;
  int ras_falls = 0, lo_run = 0, hi_run = 0, last_high = 0, cas_lo = 0, cas_hi = 1000;
  bit p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_dqoe = 1'b0, p_rsp = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        ras_falls++;
        m_row = d_addr;
        last_high = hi_run;
        hi_run = 0;
        chk(d_addr == cur_row, "R2 row at RAS fall", int'(d_addr), int'(cur_row));
      end
      if (!ras_n) lo_run++;
      else begin
        if (!p_ras) begin
          chk(lo_run <= T_RAS_MAX, "R5 RAS low length", lo_run, T_RAS_MAX);
          lo_run = 0;
        end
        hi_run++;
      end
      if (p_cas && !cas_n) begin
        chk(d_addr == cur_col, "R2 column at CAS fall", int'(d_addr), int'(cur_col));
        chk(cas_hi >= T_CP, "R10 CAS precharge", cas_hi, T_CP);
        chk(!ras_n, "R2 CAS under RAS", int'(ras_n), 0);
        cas_lo = 0;
        if (!we_n) begin
          chk(!p_we && p_dqoe && dq_oe && oe_n, "R6 early write order",
              int'({p_we, p_dqoe, dq_oe, oe_n}), 4'b0111);
          dmem[int'({m_row, d_addr})] = dq_out;
        end
      end
      if (!p_cas && cas_n) begin
        chk(cas_lo == T_CAS, "R10 CAS low width", cas_lo, T_CAS);
        cas_hi = 0;
      end
      if (!cas_n) cas_lo++;
      else cas_hi++;
      if (!oe_n) chk(!cas_n && !dq_oe && we_n, "R7 OE only in read CAS",
                     int'({cas_n, dq_oe, we_n}), 3'b001);
      if (!we_n) chk(oe_n, "R6 OE high during write", int'(oe_n), 1);
      if (rsp_valid) begin
        chk(cas_lo == T_RD + 1, "R8 read sample delay", cas_lo, T_RD + 1);
        chk(!p_rsp, "R8 single-cycle valid", int'(p_rsp), 0);
        chk(!req_ready, "R9 busy during read", int'(req_ready), 0);
      end
      // data only valid once access delay has elapsed
      if (!ras_n && !cas_n && !oe_n && cas_lo >= T_RD)
        dq_in = dmem.exists(int'({m_row, d_addr})) ? dmem[int'({m_row, d_addr})] : 4'h0;
      else
        dq_in = ~(dmem.exists(int'({m_row, d_addr})) ? dmem[int'({m_row, d_addr})] : 4'h0);
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_dqoe = dq_oe; p_rsp = rsp_valid;
    end
  end

  task automatic op(input bit we, input logic [19:0] a, input logic [3:0] wd);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    cur_row = a[19:10]; cur_col = a[9:0];
    guard = 0;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    if (we) ref_mem[int'(a)] = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready low after accept", int'(req_ready), 0);
    if (!we) begin
      guard = 0;
      while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
      chk(rsp_rdata == ref_rd(a), "R8 R6 read data", int'(rsp_rdata), int'(ref_rd(a)));
    end
    guard = 0;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    chk(guard < 200, "R9 ready returns", guard, 0);
    #0.5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rsp_valid, "R1 strobes in reset",
        int'({ras_n, cas_n, we_n, oe_n, dq_oe, rsp_valid}), 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && req_ready, "R1 state after reset",
        int'({ras_n, cas_n, we_n, oe_n, dq_oe, req_ready}), 6'b111101);

    // page hit after activation
    op(1'b1, {10'd5, 10'd1}, 4'hA);
    f0 = ras_falls;
    op(1'b0, {10'd5, 10'd1}, 4'h0);
    chk(ras_falls == f0, "R3 page hit no RAS cycle", ras_falls - f0, 0);

    // open row closes on its own
    repeat (40) @(negedge clk);
    chk(ras_n == 1'b1, "R5 idle row closed", int'(ras_n), 1);

    // row miss
    op(1'b1, {10'd7, 10'd3}, 4'h5);
    f0 = ras_falls;
    op(1'b0, {10'd9, 10'd3}, 4'h0);
    chk(ras_falls - f0 == 1, "R4 miss reactivates once", ras_falls - f0, 1);
    chk(last_high == T_RP, "R4 precharge length", last_high, T_RP);
    op(1'b0, {10'd7, 10'd3}, 4'h0);

    // back-to-back hits must run into the budget
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) op(1'b0, {10'd7, 10'd3}, 4'h0);
    chk(ras_falls - f0 >= 1, "R5 budget forces reopen", ras_falls - f0, 1);

    // writes to every column edge
    op(1'b1, {10'd1023, 10'd1023}, 4'hC);
    op(1'b1, {10'd1023, 10'd0}, 4'h3);
    op(1'b0, {10'd1023, 10'd1023}, 4'h0);
    op(1'b0, {10'd1023, 10'd0}, 4'h0);

    for (int i = 0; i < 400; i++) begin
      logic [9:0] r;
      logic [9:0] c;
      int gap;
      case ($urandom_range(0, 4))
        0: r = 10'd0;
        1: r = 10'd1;
        2: r = 10'd2;
        3: r = 10'd512;
        default: r = 10'd1023;
      endcase
      c = 10'($urandom_range(0, 7));
      op($urandom_range(0, 1) == 1, {r, c}, 4'($urandom_range(0, 15)));
      gap = $urandom_range(0, 12);
      repeat (gap) @(negedge clk);
    end

    repeat (40) @(negedge clk);
    chk(ras_n == 1'b1, "R5 final row closed", int'(ras_n), 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule